// File: doc/BRIEF.md
# Cascaded Event Interrupt Multiplexer

This block gathers up to 96 single-cycle event pulses into three 32-bit pending words. It drives three level-sensitive interrupt lines, A, B and C. Each line has its own bank of three 32-bit enable masks. A line is high whenever any pending bit in any word meets a set bit in the matching word of its bank.

The two upper pending words are also summarised into word 0. Word 0 bit 30 stands for "word 1 holds something" and bit 31 stands for "word 2 holds something". Software can enable these two bits like any other bit, so a whole upper word can be routed through a single mask bit.

Software uses a simple write port to clear pending bits and to program the masks, and a combinational read port to inspect them. A separate hardware clear input removes one event at a time. Software cannot clear the summary bits directly. Each one drops only when its word becomes empty.

Top module: `intmux_cascade`

## Requirements
- R1: A pulse on `evt_pulse[n]` sets bit n[4:0] of pending word n[6:5]. The bit reads back as set after the clock edge that samples the pulse, and several pulses in the same cycle all land.
- R2: Word 0 bit 30 is set exactly when pending word 1 is non-zero, and word 0 bit 31 is set exactly when pending word 2 is non-zero.
- R3: A write to pending word 0 clears every bit written as 1, except bits 31 and 30, which keep their value.
- R4: A write to pending word 1 has no effect on any pending word.
- R5: A write to pending word 2 clears every bit written as 1. If word 2 becomes zero, word 0 bit 31 drops in the same cycle.
- R6: When `hclr_valid` is high, the bit selected by `hclr_num` (same numbering as R1) is cleared. If this empties word 1 or word 2, word 0 bit 30 or bit 31 drops.
- R7: `irq_out[k]` (k=0 for A, 1 for B, 2 for C) is the OR over the three words of pending AND bank-k mask. It is registered, so it reflects the pending and mask state one clock edge earlier.
- R8: A mask write on its own raises an output for events that are already pending, and a later mask write drops it again.
- R9: When an event pulse and a clear (software or hardware) hit the same bit in the same cycle, the bit ends set, and the summary bit of its word ends set.
- R10: Reset (synchronous, active high) clears all pending and mask words and drives all three outputs low.
- R11: Event pulses and hardware clears aimed at word 0 bits 30 and 31 are ignored. Hardware clear numbers 96 to 127 are ignored.
- R12: Addressing works as follows.
  - Address bits [3:2] select the bank: 0 pending, 1 mask A, 2 mask B, 3 mask C.
  - Address bits [1:0] select the word, 0 to 2.
  - Word index 3 reads as zero and ignores writes.
  - Masks read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 96 | One-cycle event pulses, bit n is event n |
| hclr_valid | input | 1 | Hardware single-event clear strobe |
| hclr_num | input | 7 | Event number to clear |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address {bank, word} |
| wr_data | input | 32 | Write data (1 = clear for pending, value for masks) |
| rd_addr | input | 4 | Read address {bank, word} |
| rd_data | output | 32 | Read data, combinational |
| irq_out | output | 3 | Interrupt levels A, B, C |

## Verification
An event pulse and a clear aimed at the same bit can arrive in one cycle. The clear may be a software write or a hardware single-event clear, and it may empty an upper word just as a new event refills it. The bench drives both stimuli in a single cycle on word 0, word 1 and word 2, then reads back every register and the three outputs. The expected state comes from a bench model that applies clears before sets, so the event always wins and the summary bits follow the final word contents.

// File: rtl/intmux_pkg.sv
package intmux_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 3;
    localparam int N_BANKS = 3;
    localparam int N_EVT   = WORD_W * N_WORDS;
    localparam int BIT_W   = $clog2(WORD_W);
    localparam int WIDX_W  = $clog2(N_WORDS);
    localparam int NUM_W   = WIDX_W + BIT_W;
    localparam int ADDR_W  = 2 + WIDX_W;

    // word roles: base word holds summaries, one read-only upper word, one clearable
    localparam int W_BASE = 0;
    localparam int W_RO   = 1;
    localparam int W_TOP  = 2;
    localparam int SUM1_POS = WORD_W - 2;  // summarises W_RO
    localparam int SUM2_POS = WORD_W - 1;  // summarises W_TOP

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [N_WORDS-1:0] wordset_t;
    typedef wordset_t [N_BANKS-1:0] maskset_t;

    typedef enum logic [1:0] {
        SEL_PEND   = 2'd0,
        SEL_MASK_A = 2'd1,
        SEL_MASK_B = 2'd2,
        SEL_MASK_C = 2'd3
    } regsel_e;

    typedef struct packed {
        regsel_e           sel;
        logic [WIDX_W-1:0] word;
    } regaddr_t;

    typedef struct packed {
        logic [WIDX_W-1:0] word;
        logic [BIT_W-1:0]  idx;
    } evtnum_t;

    function automatic wordset_t num_to_onehot(evtnum_t n, logic v);
        wordset_t r = '0;
        if (v && (int'(n.word) < N_WORDS))
            r[n.word][n.idx] = 1'b1;
        return r;
    endfunction

    function automatic logic any_hit(wordset_t p, wordset_t m);
        return |(p & m);
    endfunction
endpackage

// File: rtl/intmux_pend.sv
module intmux_pend
    import intmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wordset_t          evt_set,
    input  wordset_t          hclr_set,
    input  logic              sw_wr,
    input  logic [WIDX_W-1:0] sw_word,
    input  word_t             sw_data,
    output wordset_t          pend_q
);
    wordset_t sw_clr;
    wordset_t raw;
    wordset_t pend_d;
    logic     drop_ro;
    logic     drop_top;

    always_comb begin
        sw_clr = '0;
        if (sw_wr) begin
            if (int'(sw_word) == W_BASE)
                sw_clr[W_BASE] = sw_data;   // summary positions are rebuilt below
            else if (int'(sw_word) == W_TOP)
                sw_clr[W_TOP] = sw_data;
        end
        // clears first, then sets: an event beats a clear of the same bit
        for (int w = 0; w < N_WORDS; w++)
            raw[w] = (pend_q[w] & ~(sw_clr[w] | hclr_set[w])) | evt_set[w];

        drop_ro  = (|hclr_set[W_RO]) && (raw[W_RO] == '0);
        drop_top = ((|hclr_set[W_TOP]) || (|sw_clr[W_TOP])) && (raw[W_TOP] == '0);

        pend_d = raw;
        pend_d[W_BASE][SUM1_POS] = (|evt_set[W_RO])
                                 || (pend_q[W_BASE][SUM1_POS] && !drop_ro);
        pend_d[W_BASE][SUM2_POS] = (|evt_set[W_TOP])
                                 || (pend_q[W_BASE][SUM2_POS] && !drop_top);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end
endmodule

// File: rtl/intmux_mask.sv
module intmux_mask
    import intmux_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  regaddr_t addr,
    input  word_t    data,
    output maskset_t mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en && addr.sel != SEL_PEND && int'(addr.word) < N_WORDS) begin
            for (int b = 0; b < N_BANKS; b++)
                for (int w = 0; w < N_WORDS; w++)
                    if (int'(addr.sel) == b + 1 && int'(addr.word) == w)
                        mask_q[b][w] <= data;
        end
    end
endmodule

// File: rtl/intmux_route.sv
module intmux_route
    import intmux_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wordset_t           pend,
    input  maskset_t           mask,
    output logic [N_BANKS-1:0] irq_q
);
    logic [N_BANKS-1:0] hit;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        assign hit[b] = any_hit(pend, mask[b]);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= hit;
    end
endmodule

// File: rtl/intmux_cascade.sv
module intmux_cascade
    import intmux_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_EVT-1:0]   evt_pulse,
    input  logic               hclr_valid,
    input  logic [NUM_W-1:0]   hclr_num,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    output logic [N_BANKS-1:0] irq_out
);
    regaddr_t wr_a;
    regaddr_t rd_a;
    wordset_t evt_set;
    wordset_t hclr_set;
    wordset_t pend_q;
    maskset_t mask_q;

    assign wr_a     = regaddr_t'(wr_addr);
    assign rd_a     = regaddr_t'(rd_addr);
    assign evt_set  = wordset_t'(evt_pulse);
    assign hclr_set = num_to_onehot(evtnum_t'(hclr_num), hclr_valid);

    intmux_pend u_pend (
        .clk      (clk),
        .rst      (rst),
        .evt_set  (evt_set),
        .hclr_set (hclr_set),
        .sw_wr    (wr_en && wr_a.sel == SEL_PEND),
        .sw_word  (wr_a.word),
        .sw_data  (wr_data),
        .pend_q   (pend_q)
    );

    intmux_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (wr_a),
        .data   (wr_data),
        .mask_q (mask_q)
    );

    intmux_route u_route (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend_q),
        .mask  (mask_q),
        .irq_q (irq_out)
    );

    always_comb begin
        rd_data = '0;
        if (int'(rd_a.word) < N_WORDS) begin
            case (rd_a.sel)
                SEL_PEND:   rd_data = pend_q[rd_a.word];
                SEL_MASK_A: rd_data = mask_q[0][rd_a.word];
                SEL_MASK_B: rd_data = mask_q[1][rd_a.word];
                default:    rd_data = mask_q[2][rd_a.word];
            endcase
        end
    end
endmodule

// File: rtl/intmux_cascade_chk.sv
module intmux_cascade_chk
    import intmux_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [N_EVT-1:0]   evt_pulse,
    input logic               hclr_valid,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input wordset_t           pend_q,
    input maskset_t           mask_q,
    input logic [N_BANKS-1:0] irq_out
);
    logic [N_BANKS-1:0] exp_hit;
    logic [N_EVT-1:0]   evt_ok;
    logic [N_EVT-1:0]   pend_flat;

    always_comb begin
        for (int b = 0; b < N_BANKS; b++) begin
            exp_hit[b] = 1'b0;
            for (int w = 0; w < N_WORDS; w++)
                exp_hit[b] = exp_hit[b] | (|(pend_q[w] & mask_q[b][w]));
        end
    end

    assign evt_ok    = evt_pulse & ~(N_EVT'(2'b11) << SUM1_POS);
    assign pend_flat = pend_q;

    // R7: each output is the registered OR of pending AND mask
    a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(exp_hit)));

    // R2: summary of the read-only upper word
    a_r2_summary_low: assert property (@(posedge clk) disable iff (rst)
        pend_q[W_BASE][SUM1_POS] == (|pend_q[W_RO]));

    // R2 / R5 / R6: summary of the clearable upper word
    a_r2_summary_high: assert property (@(posedge clk) disable iff (rst)
        pend_q[W_BASE][SUM2_POS] == (|pend_q[W_TOP]));

    // R1 / R9: every sampled event ends pending, whatever clear came with it
    a_r9_event_lands: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_flat & $past(evt_ok)) == $past(evt_ok)));

    // R4: a write to the read-only word leaves it unchanged
    a_r4_word1_readonly: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(W_RO) && !hclr_valid
         && evt_pulse[2*WORD_W-1:WORD_W] == '0) |=> $stable(pend_q[W_RO]));

    // R10: reset empties the state and silences the outputs
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (irq_out == '0 && pend_q == '0 && mask_q == '0));
endmodule

bind intmux_cascade intmux_cascade_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_pulse  (evt_pulse),
    .hclr_valid (hclr_valid),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .irq_out    (irq_out)
);

// File: tb/tb_intmux_cascade.sv
`timescale 1ns/100ps
module tb_intmux_cascade;
    import intmux_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N_EVT-1:0] evt_pulse = '0;
    logic             hclr_valid = 1'b0;
    logic [6:0]       hclr_num = '0;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [3:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic [2:0]       irq_out;

    always #2 clk = ~clk;

    intmux_cascade dut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .hclr_valid(hclr_valid),
        .hclr_num(hclr_num), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] mp [3];
    logic [31:0] mm [3][3];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic void m_clear_all();
        for (int w = 0; w < 3; w++) begin
            mp[w] = '0;
            for (int b = 0; b < 3; b++) mm[b][w] = '0;
        end
    endfunction

    function automatic void m_event(int n);
        int w = n / 32;
        int i = n % 32;
        if (w == 0 && i >= 30) return;
        mp[w][i] = 1'b1;
        if (w == 1) mp[0][30] = 1'b1;
        if (w == 2) mp[0][31] = 1'b1;
    endfunction

    function automatic void m_hclr(int n);
        int w = n / 32;
        int i = n % 32;
        if (n >= 96 || (w == 0 && i >= 30)) return;
        mp[w][i] = 1'b0;
        if (w == 1 && mp[1] == 0) mp[0][30] = 1'b0;
        if (w == 2 && mp[2] == 0) mp[0][31] = 1'b0;
    endfunction

    function automatic void m_write(logic [3:0] a, logic [31:0] d);
        int s = int'(a[3:2]);
        int w = int'(a[1:0]);
        if (w == 3) return;
        if (s != 0) begin
            mm[s-1][w] = d;
        end else if (w == 0) begin
            mp[0] = mp[0] & ~(d & 32'h3FFF_FFFF);
        end else if (w == 2) begin
            mp[2] = mp[2] & ~d;
            if (mp[2] == 0) mp[0][31] = 1'b0;
        end
    endfunction

    task automatic apply(logic [N_EVT-1:0] ev, bit hv, int hn, bit we,
                         logic [3:0] wa, logic [31:0] wd);
        @(negedge clk);
        evt_pulse = ev; hclr_valid = hv; hclr_num = 7'(hn);
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(negedge clk);
        evt_pulse = '0; hclr_valid = 1'b0; wr_en = 1'b0;
        if (hv) m_hclr(hn);
        if (we) m_write(wa, wd);
        for (int n = 0; n < N_EVT; n++) if (ev[n]) m_event(n);
    endtask

    task automatic ev1(int n);
        logic [N_EVT-1:0] v = '0;
        v[n] = 1'b1;
        apply(v, 0, 0, 0, 4'h0, 32'h0);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        apply('0, 0, 0, 1, a, d);
    endtask

    task automatic hc(int n);
        apply('0, 1, n, 0, 4'h0, 32'h0);
    endtask

    // one idle cycle so the registered outputs catch up, then read everything
    task automatic check_all(string tag);
        logic [31:0] e;
        logic [2:0] ei;
        @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #0.1;
            if (a % 4 == 3)      e = '0;
            else if (a / 4 == 0) e = mp[a % 4];
            else                 e = mm[a / 4 - 1][a % 4];
            chk($sformatf("%s R12 addr=%0d", tag, a), rd_data, e);
        end
        for (int b = 0; b < 3; b++)
            ei[b] = |((mp[0] & mm[b][0]) | (mp[1] & mm[b][1]) | (mp[2] & mm[b][2]));
        chk({tag, " R7 irq"}, {29'b0, irq_out}, {29'b0, ei});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog all-requirements act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N_EVT-1:0] pat;
        m_clear_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R10 reset state");

        // masks with distinct patterns per bank (R12 read back)
        for (int w = 0; w < 3; w++) begin
            wr(4'(4 + w), 32'h5555_5555);
            wr(4'(8 + w), 32'hAAAA_AAAA);
        end
        wr(4'd14, 32'hFF00_0000);
        check_all("R12 mask program");

        // R1 R2 R6 R11: single event sweep, then hardware clear of it
        for (int n = 0; n < 96; n++) begin
            ev1(n);
            check_all($sformatf("R1 R2 R11 event %0d", n));
            hc(n);
            check_all($sformatf("R6 hw clear %0d", n));
        end

        // R1 multi-event patterns, then software clears R3 R4 R5
        for (int p = 0; p < 6; p++) begin
            pat = {32'h0F0F_1234, 32'h8001_00F0, 32'hFFFF_FFFF} << (p * 7);
            apply(pat, 0, 0, 0, 4'h0, 32'h0);
            check_all($sformatf("R1 multi pattern %0d", p));
        end
        wr(4'd0, 32'hFFFF_FFFF);
        check_all("R3 clear word0 keeps summaries");
        wr(4'd1, 32'hFFFF_FFFF);
        check_all("R4 word1 write ignored");
        wr(4'd2, 32'h0000_FFFF);
        check_all("R5 partial clear word2");
        wr(4'd2, 32'hFFFF_FFFF);
        check_all("R5 empty word2 drops summary");
        for (int n = 32; n < 64; n++) hc(n);
        check_all("R6 empty word1 drops summary");

        // R8 mask changes with events already pending
        for (int a = 4; a < 16; a++) if (a % 4 != 3) wr(4'(a), 32'h0);
        ev1(5); ev1(40); ev1(70);
        check_all("R8 all masks off");
        wr(4'd5, 32'h0000_0100);
        check_all("R8 mask A raises");
        wr(4'd5, 32'h0);
        check_all("R8 mask A drops");
        wr(4'd8, 32'h8000_0000);
        check_all("R8 mask B on summary bit");
        wr(4'd14, 32'h0000_0040);
        check_all("R8 mask C raises");
        wr(4'd2, 32'hFFFF_FFFF);
        check_all("R8 R5 clear drops B and C");

        // R9 same-cycle event and clear
        pat = '0; pat[10] = 1'b1;
        apply(pat, 0, 0, 1, 4'd0, 32'h0000_0400);
        check_all("R9 event beats sw clear word0");
        pat = '0; pat[72] = 1'b1;
        apply(pat, 0, 0, 1, 4'd2, 32'hFFFF_FFFF);
        check_all("R9 event beats sw clear word2");
        hc(40);
        pat = '0; pat[33] = 1'b1;
        ev1(33);
        apply(pat, 1, 33, 0, 4'h0, 32'h0);
        check_all("R9 event beats hw clear word1");

        // R11 ignored positions, R12 word index 3
        ev1(31); ev1(30);
        check_all("R11 word0 summary events ignored");
        hc(30); hc(100);
        check_all("R11 hw clear ignored");
        wr(4'd3, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF); wr(4'd15, 32'hFFFF_FFFF);
        check_all("R12 word3 ignored");

        // R10 mid-run reset
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        m_clear_all();
        check_all("R10 mid-run reset");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule